// File: doc/BRIEF.md
# Debug Port Freeze-Detect Poller

This block sits on the host side of a three-wire serial debug port running in asynchronous mode. It generates the debug clock, drives the serial command line into the target and samples the target's serial response line. Its only job is to learn whether the target processor is halted in debug mode, using nothing but the serial bitstream. No dedicated freeze or status pin is needed.

While polling is enabled, the block waits for the target to signal ready, then shifts in a no-operation trap-mode command. It captures the response frame that comes back over the same clock periods and decodes the two status bits together with the freeze and download flags. It then starts again. A response whose status carries no flags leaves the halted/running view as it was, and polling continues until a usable frame arrives. A programmable divider sets the debug clock speed, and a programmable limit turns a target that never becomes ready into an error indication.

Top module: `dbg_freeze_poller`

## Requirements
- R1: While reset is active and right after it, `dclk_o`, `dsi_o`, `halted_o`, `running_o`, `dl_o`, `err_o`, `frame_vld_o` are 0 and `stat_o` is 2'b00.
- R2: The debug clock is high for H system clocks and low for H system clocks, where H = max(`div_i`, 2), so a period is never shorter than 4 system clocks. It stays low while the block is idle.
- R3: Each command shifts the 9-bit pattern 9'b111000000, most significant bit first, on `dsi_o`. Each bit changes only on a falling debug-clock edge. `dsi_o` is 0 between commands.
- R4: A command starts only after `dso_i` has been sampled low (ready) on a rising debug-clock edge. While `dso_i` is sampled high, no start bit is sent.
- R5: The response is sampled on the 9 rising edges of a command, in this order: ready bit, status bit s0, status bit s1, freeze bit, download bit, then four unused bits. `stat_o` is updated to {s0,s1} after every frame.
- R6: When {s0,s1} is 01, 10 or 11, the frame sets `halted_o` = freeze, `running_o` = not freeze and `dl_o` = download bit.
- R7: When {s0,s1} is 00, `halted_o`, `running_o` and `dl_o` keep their previous values, `frame_vld_o` still pulses and polling continues.
- R8: `frame_vld_o` is high for exactly one system clock per decoded frame.
- R9: While `poll_en_i` is high, frames repeat without end. After it falls, at most the current frame completes. The block then goes idle with `dclk_o` and `dsi_o` low and no further frames.
- R10: When `tmo_i` is nonzero and `dso_i` is sampled high on `tmo_i` consecutive rising edges while waiting, `err_o` is set and `halted_o` and `running_o` are cleared. Waiting then continues, and the next decoded frame clears `err_o`. When `tmo_i` is 0 there is no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en_i | input | 1 | Level: keep polling while high |
| div_i | input | DIV_W (8) | Debug clock half period in system clocks (minimum 2 applied) |
| tmo_i | input | TMO_W (8) | Ready timeout in debug clock periods; 0 disables |
| dso_i | input | 1 | Serial response line from target |
| dclk_o | output | 1 | Debug clock to target |
| dsi_o | output | 1 | Serial command line to target |
| halted_o | output | 1 | Target last reported in debug mode |
| running_o | output | 1 | Target last reported executing |
| dl_o | output | 1 | Download flag from last usable frame |
| stat_o | output | 2 | Status code {s0,s1} of the last frame |
| frame_vld_o | output | 1 | One-cycle pulse per decoded frame |
| err_o | output | 1 | Ready timeout occurred since last frame |

## Verification
The assertions assume that `div_i` and `tmo_i` are static while a frame is in flight. They also assume that `dso_i` changes only in response to a rising debug-clock edge, as a target clocked by `dclk_o` would do. The bench meets both conditions. It changes the divider only between measurements, and only in ways that cannot break the two-cycle minimum. The serial response comes from a behavioural target clocked by `dclk_o` itself. Response contents are changed only between frames, and the check waits for the second following frame, so each frame checked carries exactly the intended status.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } poll_st_e;

  // shortest permitted debug clock half period, in system clocks
  localparam int unsigned MIN_HALF = 2;

endpackage

// File: rtl/dbgp_clkgen.sv
module dbgp_clkgen
  import dbgp_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             dclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             tick;

  always_comb begin
    half = (div_i < HALF_MIN) ? HALF_MIN : div_i;
    tick = run_i && (cnt_q >= (half - 1'b1));
  end

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run_i) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign dclk_o = phase_q;
  assign rise_o = tick & ~phase_q;
  assign fall_o = tick &  phase_q;

  // R2
  dclk_min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dclk_o) |=> $stable(dclk_o));

endmodule

// File: rtl/dbgp_shift.sv
module dbgp_shift #(
  parameter int unsigned     N   = 9,
  parameter logic [N-1:0]    PAT = 9'b111000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         dso_i,
  input  logic         dclk_i,
  output logic         dsi_o,
  output logic [N-1:0] resp_o,
  output logic         done_o
);

  localparam int unsigned    IDX_W = $clog2(N + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [N-1:0]     resp_q, resp_d;
  logic             dsi_q, dsi_d;
  logic             done_q, done_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    resp_d   = resp_q;
    dsi_d    = dsi_q;
    done_d   = 1'b0;
    if (load_i) begin
      active_d = 1'b1;
      idx_d    = '0;
    end
    if (fall_i) begin
      dsi_d = active_q ? PAT[LAST - idx_q] : 1'b0;
    end
    if (rise_i && active_q) begin
      resp_d = {resp_q[N-2:0], dso_i};
      if (idx_q == LAST) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      resp_q   <= '0;
      dsi_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      resp_q   <= resp_d;
      dsi_q    <= dsi_d;
      done_q   <= done_d;
    end
  end

  assign dsi_o  = dsi_q;
  assign resp_o = resp_q;
  assign done_o = done_q;

  // R3
  dsi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dsi_o) |-> $fell(dclk_i));

endmodule

// File: rtl/dbgp_decode.sv
module dbgp_decode #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic         tmo_i,
  input  logic [N-1:0] resp_i,
  output logic         halted_o,
  output logic         running_o,
  output logic         dl_o,
  output logic [1:0]   stat_o,
  output logic         frame_vld_o,
  output logic         err_o
);

  // field positions: the first sampled bit lands in the top position
  localparam int unsigned P_S0  = N - 2;
  localparam int unsigned P_S1  = N - 3;
  localparam int unsigned P_FRZ = N - 4;
  localparam int unsigned P_DL  = N - 5;

  logic       halted_q, halted_d;
  logic       running_q, running_d;
  logic       dl_q, dl_d;
  logic [1:0] stat_q, stat_d;
  logic       vld_q, vld_d;
  logic       err_q, err_d;
  logic [1:0] code;

  always_comb begin
    code      = {resp_i[P_S0], resp_i[P_S1]};
    halted_d  = halted_q;
    running_d = running_q;
    dl_d      = dl_q;
    stat_d    = stat_q;
    err_d     = err_q;
    vld_d     = strobe_i;
    if (strobe_i) begin
      stat_d = code;
      err_d  = 1'b0;
      if (code != 2'b00) begin
        halted_d  =  resp_i[P_FRZ];
        running_d = ~resp_i[P_FRZ];
        dl_d      =  resp_i[P_DL];
      end
    end else if (tmo_i) begin
      err_d     = 1'b1;
      halted_d  = 1'b0;
      running_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q  <= 1'b0;
      running_q <= 1'b0;
      dl_q      <= 1'b0;
      stat_q    <= 2'b00;
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      halted_q  <= halted_d;
      running_q <= running_d;
      dl_q      <= dl_d;
      stat_q    <= stat_d;
      vld_q     <= vld_d;
      err_q     <= err_d;
    end
  end

  assign halted_o    = halted_q;
  assign running_o   = running_q;
  assign dl_o        = dl_q;
  assign stat_o      = stat_q;
  assign frame_vld_o = vld_q;
  assign err_o       = err_q;

  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> !frame_vld_o);

  // R6
  halt_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(halted_o) |-> (frame_vld_o || err_o));

endmodule

// File: rtl/dbg_freeze_poller.sv
module dbg_freeze_poller
  import dbgp_pkg::*;
#(
  parameter int unsigned  DIV_W    = 8,
  parameter int unsigned  TMO_W    = 8,
  parameter int unsigned  CMD_BITS = 9,
  parameter logic [CMD_BITS-1:0] CMD_PAT = 9'b111000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             dso_i,
  output logic             dclk_o,
  output logic             dsi_o,
  output logic             halted_o,
  output logic             running_o,
  output logic             dl_o,
  output logic [1:0]       stat_o,
  output logic             frame_vld_o,
  output logic             err_o
);

  localparam int unsigned CW = TMO_W + 1;

  poll_st_e             st_q, st_d;
  logic [TMO_W-1:0]     tcnt_q, tcnt_d;
  logic                 run, rise, fall, load, done, tmo_hit;
  logic [CMD_BITS-1:0]  resp;

  assign run = (st_q != ST_IDLE);

  dbgp_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .div_i  (div_i),
    .dclk_o (dclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  dbgp_shift #(.N(CMD_BITS), .PAT(CMD_PAT)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .rise_i (rise),
    .fall_i (fall),
    .dso_i  (dso_i),
    .dclk_i (dclk_o),
    .dsi_o  (dsi_o),
    .resp_o (resp),
    .done_o (done)
  );

  dbgp_decode #(.N(CMD_BITS)) i_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (done),
    .tmo_i       (tmo_hit),
    .resp_i      (resp),
    .halted_o    (halted_o),
    .running_o   (running_o),
    .dl_o        (dl_o),
    .stat_o      (stat_o),
    .frame_vld_o (frame_vld_o),
    .err_o       (err_o)
  );

  always_comb begin
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    load    = 1'b0;
    tmo_hit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (poll_en_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (fall && !poll_en_i) begin
          st_d   = ST_IDLE;
          tcnt_d = '0;
        end else if (rise && poll_en_i) begin
          if (!dso_i) begin
            load   = 1'b1;
            st_d   = ST_SHIFT;
            tcnt_d = '0;
          end else if (tmo_i != '0) begin
            if ((CW'(tcnt_q) + 1'b1) == CW'(tmo_i)) begin
              tmo_hit = 1'b1;
              tcnt_d  = '0;
            end else begin
              tcnt_d  = tcnt_q + 1'b1;
            end
          end
        end
      end
      ST_SHIFT: begin
        if (done) st_d = ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R9
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !dclk_o);

  // R4
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && $past(st_q) == ST_WAIT) |-> !$past(dso_i));

  // R10
  err_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(st_q) == ST_WAIT));

endmodule

// File: tb/test_dbg_freeze_poller.sv
module test_dbg_freeze_poller;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_en = 1'b0;
  logic [7:0] div = 8'd2;
  logic [7:0] tmo = 8'd0;
  logic       dso = 1'b0;
  logic       dclk, dsi, halted, running, dl, frame_vld, err;
  logic [1:0] stat;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dbg_freeze_poller i_dbg_freeze_poller (
    .clk(clk), .rst_n(rst_n), .poll_en_i(poll_en), .div_i(div), .tmo_i(tmo),
    .dso_i(dso), .dclk_o(dclk), .dsi_o(dsi), .halted_o(halted),
    .running_o(running), .dl_o(dl), .stat_o(stat), .frame_vld_o(frame_vld),
    .err_o(err)
  );

  // behavioural target: samples dsi and updates dso on rising dclk
  logic       t_idle = 1'b0;
  logic [7:0] t_resp = 8'h00;
  logic [7:0] t_cur  = 8'h00;
  logic [3:0] t_cnt  = 4'd0;
  logic [8:0] t_cap  = 9'd0;
  logic [8:0] t_last = 9'd0;
  int         t_starts = 0;

  always @(posedge dclk) begin
    if (t_cnt == 4'd0) begin
      if (dsi) begin
        t_cap    <= 9'd1;
        t_cur    <= t_resp;
        dso      <= t_resp[7];
        t_cnt    <= 4'd1;
        t_starts <= t_starts + 1;
      end else begin
        dso <= t_idle;
      end
    end else begin
      t_cap <= {t_cap[7:0], dsi};
      if (t_cnt == 4'd8) begin
        t_last <= {t_cap[7:0], dsi};
        t_cnt  <= 4'd0;
        dso    <= t_idle;
      end else begin
        dso   <= t_cur[7 - t_cnt];
        t_cnt <= t_cnt + 4'd1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_vld();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!frame_vld && g < 4000);
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    do @(negedge clk); while (dclk);
    do @(negedge clk); while (!dclk);
    while (dclk) begin hi++; @(negedge clk); end
    while (!dclk) begin lo++; @(negedge clk); end
  endtask

  // entries: {s0s1[1:0], freeze, download, exp_halted, exp_running, exp_dl}
  localparam int NV = 6;
  localparam logic [6:0] VEC [NV] = '{
    7'b01_1_0_1_0_0,
    7'b00_0_1_1_0_0,
    7'b10_0_1_0_1_1,
    7'b11_1_1_1_0_1,
    7'b00_1_0_1_0_1,
    7'b01_0_0_0_1_0
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo, s0, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dclk", dclk, 0);
    check("R1 dsi", dsi, 0);
    check("R1 halted/running", {halted, running}, 0);
    check("R1 err/vld/dl", {err, frame_vld, dl}, 0);
    check("R1 stat", stat, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 idle dclk low", dclk, 0);
    check("R4 no start while idle", t_starts, 0);

    poll_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      t_resp = {VEC[i][6:5], VEC[i][4], VEC[i][3], 4'b0000};
      wait_vld();
      wait_vld();
      check($sformatf("R5 stat vec%0d", i), stat, int'(VEC[i][6:5]));
      check($sformatf("R6/R7 halted vec%0d", i), halted, VEC[i][2]);
      check($sformatf("R6/R7 running vec%0d", i), running, VEC[i][1]);
      check($sformatf("R6/R7 dl vec%0d", i), dl, VEC[i][0]);
    end
    check("R3 command pattern", t_last, 9'b111000000);
    @(negedge clk);
    check("R8 vld one cycle", frame_vld, 0);

    // R2 divider
    measure(hi, lo);
    check("R2 high div2", hi, 2);
    check("R2 low div2", lo, 2);
    div = 8'd5;
    measure(hi, lo);
    measure(hi, lo);
    check("R2 high div5", hi, 5);
    check("R2 low div5", lo, 5);
    div = 8'd1;
    measure(hi, lo);
    measure(hi, lo);
    check("R2 high div1 clamp", hi, 2);
    check("R2 low div1 clamp", lo, 2);
    div = 8'd2;

    // R3 dsi low between commands: during a wait phase
    t_idle = 1'b1;
    repeat (100) @(negedge clk);
    s0 = t_starts;
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (dsi) cnt++;
    end
    check("R4 no start while busy", t_starts - s0, 0);
    check("R3 dsi low while waiting", cnt, 0);
    check("R10 no timeout when limit zero", err, 0);

    // R10 timeout
    tmo = 8'd3;
    cnt = 0;
    while (!err && cnt < 200) begin @(negedge clk); cnt++; end
    check("R10 err set", err, 1);
    check("R10 halted/running cleared", {halted, running}, 0);
    t_idle = 1'b0;
    wait_vld();
    check("R10 err cleared by frame", err, 0);
    check("R10 state restored", {halted, running}, 2'b01);
    tmo = 8'd0;

    // R9 stop polling
    poll_en = 1'b0;
    repeat (200) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (frame_vld || dclk || dsi) cnt++;
    end
    check("R9 idle after disable", cnt, 0);
    poll_en = 1'b1;
    wait_vld();
    check("R9 resumes", frame_vld, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule